// File: doc/BRIEF.md
# Fall-Through Fetch Steering and Wrong-Path Squash

This block owns the fetch address of an in-order five-stage pipeline. It assumes every instruction falls through and advances the fetch address by one instruction word each cycle, so the front end never waits to learn whether it fetched a branch. Branch direction and target are only known once the branch reaches execute. When execute reports that control must go elsewhere, the block loads the resolved target as the next fetch address. In the same cycle it squashes the two younger instructions, the one being fetched and the one in decode.

Alongside the fetch address the block keeps one valid bit for each latched stage (decode, execute, memory, writeback). A squashed slot clears its valid bit. The surrounding datapath gates its register-file writes, memory writes and branch resolution with these bits, so the squashed slots move down the pipe as bubbles. A guess that turns out right costs nothing. A guess that turns out wrong costs exactly two bubble cycles.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: A synchronous reset sets `pc_o` to the parameter `RESET_VEC` and clears every bit of `vld_o`. Bit 0 of `vld_o` is decode, bit 1 is execute, bit 2 is memory and bit 3 is writeback.
- R2: With no stall and no redirect, `npc_o` equals `pc_o + STEP` (default 4), and `pc_o` takes that value at the next edge. Decode becomes valid and every other valid bit shifts one stage older.
- R3: With a stall and no redirect, `pc_o` and the decode valid bit hold their values, and the execute valid bit becomes 0 (a bubble).
- R4: A redirect happens when `ex_resolve_i`, `ex_redirect_i` and the execute valid bit are all 1. A redirect makes `npc_o` equal to `ex_target_i`, and `pc_o` equals that target after the next edge.
- R5: In a redirect cycle `kill_if_o` is 1, and `kill_id_o` is 1 when decode holds a valid instruction. At the next edge the decode and execute valid bits both become 0.
- R6: A redirect takes priority over a stall. The target is loaded and the squash happens on the same edge, whatever the value of `stall_i`.
- R7: A resolve with `ex_redirect_i` at 0, or any resolve while the execute valid bit is 0, changes nothing. The block behaves as in R2 or R3, and both kill outputs stay 0.
- R8: The memory valid bit takes the old execute valid bit each cycle, and the writeback valid bit takes the old memory valid bit each cycle, stall or not.
- R9: A redirect with no stall around it gives the memory valid bit the pattern 1, 0, 0, 1 over the four following cycles: the branch, two bubbles, then the target.
- R10: `ex_redirect_i` has no effect while `ex_resolve_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze the fetch address and the decode slot |
| ex_resolve_i | input | 1 | Execute has resolved a control-flow instruction this cycle |
| ex_redirect_i | input | 1 | The resolved outcome differs from fall-through |
| ex_target_i | input | AW | Resolved target address |
| pc_o | output | AW | Address being fetched this cycle |
| npc_o | output | AW | Address that will be fetched next cycle |
| kill_if_o | output | 1 | The instruction being fetched is wrong-path |
| kill_id_o | output | 1 | The valid instruction in decode is wrong-path |
| vld_o | output | NSTG | Stage valid bits: decode, execute, memory, writeback |

## Verification
The assertions check on every cycle the local rules that connect one cycle to the next. These are the sequential step, hold under stall, the target load, the squash of the two young slots, the ageing of the older valid bits, and the fact that a kill needs a resolve. The bench's scenarios are what show the effects that span several cycles: the reset values, the two-bubble gap that a redirect leaves in the memory stage, the priority of a redirect over a stall, and the absence of any effect from a resolve that arrives while execute holds a bubble. The bench also sweeps every combination of stall, resolve and redirect from many pipeline states and compares the result with a model written from the requirements.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // Where the next fetch address comes from.
    typedef enum logic [1:0] {
        PCS_SEQ   = 2'd0,
        PCS_HOLD  = 2'd1,
        PCS_REDIR = 2'd2
    } pc_src_e;

    // Slot positions inside the valid vector; the squash logic depends on them.
    localparam int STG_DEC = 0;
    localparam int STG_EXE = 1;

endpackage

// File: rtl/fpc_steer.sv
module fpc_steer
    import fpc_pkg::*;
(
    input  logic    resolve_i,
    input  logic    redirect_i,
    input  logic    exe_valid_i,
    input  logic    stall_i,
    output logic    redir_o,
    output pc_src_e src_o
);

    // A bubble in execute cannot steer fetch.
    always_comb begin
        redir_o = resolve_i && redirect_i && exe_valid_i;
        if (redir_o) begin
            src_o = PCS_REDIR;
        end else if (stall_i) begin
            src_o = PCS_HOLD;
        end else begin
            src_o = PCS_SEQ;
        end
    end

endmodule

// File: rtl/fpc_pc_gen.sv
module fpc_pc_gen
    import fpc_pkg::*;
#(
    parameter int             AW        = 32,
    parameter int             STEP      = 4,
    parameter logic [AW-1:0]  RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  pc_src_e       src_i,
    input  logic [AW-1:0] target_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] npc_o
);

    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    typedef struct packed {
        logic [AW-1:0] pc;
    } pc_st_t;

    pc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (src_i)
            PCS_SEQ:   st_d.pc = st_q.pc + STEP_W;
            PCS_HOLD:  st_d.pc = st_q.pc;
            PCS_REDIR: st_d.pc = target_i;
            default:   st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc <= RESET_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o  = st_q.pc;
    assign npc_o = st_d.pc;

endmodule

// File: rtl/fpc_valid_pipe.sv
module fpc_valid_pipe
    import fpc_pkg::*;
#(
    parameter int NSTG = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  pc_src_e         src_i,
    output logic [NSTG-1:0] vld_o
);

    typedef struct packed {
        logic [NSTG-1:0] v;
    } vp_st_t;

    vp_st_t          st_d, st_q;
    logic [NSTG-1:0] nxt;

    for (genvar i = 0; i < NSTG; i++) begin : g_slot
        if (i == STG_DEC) begin : g_dec
            // Fetch is always active: a new slot enters decode unless frozen or squashed.
            assign nxt[i] = (src_i == PCS_SEQ)  ? 1'b1 :
                            (src_i == PCS_HOLD) ? st_q.v[i] : 1'b0;
        end else if (i == STG_EXE) begin : g_exe
            // A stall inserts a bubble; a redirect squashes the decode occupant.
            assign nxt[i] = (src_i == PCS_SEQ) ? st_q.v[i-1] : 1'b0;
        end else begin : g_old
            assign nxt[i] = st_q.v[i-1];
        end
    end

    always_comb begin
        st_d   = st_q;
        st_d.v = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.v <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.v;

endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
    import fpc_pkg::*;
#(
    parameter int             AW        = 32,
    parameter int             STEP      = 4,
    parameter int             NSTG      = 4,
    parameter logic [AW-1:0]  RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  logic            ex_resolve_i,
    input  logic            ex_redirect_i,
    input  logic [AW-1:0]   ex_target_i,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   npc_o,
    output logic            kill_if_o,
    output logic            kill_id_o,
    output logic [NSTG-1:0] vld_o
);

    pc_src_e src;
    logic    redir;

    fpc_steer u_steer (
        .resolve_i   (ex_resolve_i),
        .redirect_i  (ex_redirect_i),
        .exe_valid_i (vld_o[STG_EXE]),
        .stall_i     (stall_i),
        .redir_o     (redir),
        .src_o       (src)
    );

    fpc_pc_gen #(
        .AW        (AW),
        .STEP      (STEP),
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src),
        .target_i (ex_target_i),
        .pc_o     (pc_o),
        .npc_o    (npc_o)
    );

    fpc_valid_pipe #(
        .NSTG (NSTG)
    ) u_vld (
        .clk   (clk),
        .rst   (rst),
        .src_i (src),
        .vld_o (vld_o)
    );

    assign kill_if_o = redir;
    assign kill_id_o = redir && vld_o[STG_DEC];

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int AW   = 32,
    parameter int STEP = 4,
    parameter int NSTG = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            stall_i,
    input logic            ex_resolve_i,
    input logic            ex_redirect_i,
    input logic [AW-1:0]   ex_target_i,
    input logic [AW-1:0]   pc_o,
    input logic [AW-1:0]   npc_o,
    input logic            kill_if_o,
    input logic            kill_id_o,
    input logic [NSTG-1:0] vld_o
);

    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    logic steer;
    assign steer = ex_resolve_i && ex_redirect_i && vld_o[1];

    // R2
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !steer) |=> (pc_o == $past(pc_o) + STEP_W) && vld_o[0]);

    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !steer) |=> (pc_o == $past(pc_o)) && !vld_o[1]
                                && (vld_o[0] == $past(vld_o[0])));

    // R4, R6
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        steer |=> pc_o == $past(ex_target_i));

    // R4: the announced next address is the one that gets fetched
    a_r4_npc_match: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_o == $past(npc_o));

    // R5
    a_r5_squash: assert property (@(posedge clk) disable iff (rst)
        steer |=> !vld_o[0] && !vld_o[1]);

    a_r5_kill_pair: assert property (@(posedge clk) disable iff (rst)
        kill_id_o |-> kill_if_o);

    // R10
    a_r10_no_resolve: assert property (@(posedge clk) disable iff (rst)
        !ex_resolve_i |-> !kill_if_o && !kill_id_o);

    // R8
    for (genvar i = 2; i < NSTG; i++) begin : g_age
        a_r8_shift: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> vld_o[i] == $past(vld_o[i-1]));
    end

endmodule

bind fetch_redirect_ctrl fpc_checker #(
    .AW   (AW),
    .STEP (STEP),
    .NSTG (NSTG)
) u_chk (.*);

// File: tb/fetch_redirect_ctrl_test.sv
module fetch_redirect_ctrl_test;

    localparam int          AW   = 32;
    localparam int          STEP = 4;
    localparam int          NSTG = 4;
    localparam logic [31:0] RV   = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst;
    logic            stall_i;
    logic            ex_resolve_i;
    logic            ex_redirect_i;
    logic [AW-1:0]   ex_target_i;
    logic [AW-1:0]   pc_o;
    logic [AW-1:0]   npc_o;
    logic            kill_if_o;
    logic            kill_id_o;
    logic [NSTG-1:0] vld_o;

    always #10 clk = ~clk;

    fetch_redirect_ctrl #(
        .AW (AW), .STEP (STEP), .NSTG (NSTG), .RESET_VEC (RV)
    ) uut (
        .clk (clk), .rst (rst), .stall_i (stall_i),
        .ex_resolve_i (ex_resolve_i), .ex_redirect_i (ex_redirect_i),
        .ex_target_i (ex_target_i), .pc_o (pc_o), .npc_o (npc_o),
        .kill_if_o (kill_if_o), .kill_id_o (kill_id_o), .vld_o (vld_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model state, derived from the requirements.
    logic [31:0]     m_pc;
    logic [NSTG-1:0] m_v;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit st, input bit rs, input bit rd, input logic [31:0] tg);
        logic            redir;
        logic [31:0]     npc_e;
        logic [NSTG-1:0] v_n;
        string           tag;
        stall_i       = st;
        ex_resolve_i  = rs;
        ex_redirect_i = rd;
        ex_target_i   = tg;
        #1;
        redir = rs && rd && m_v[1];
        if (redir)          tag = st ? "R6" : "R4";
        else if (rd && !rs) tag = "R10";
        else if (rs)        tag = "R7";
        else if (st)        tag = "R3";
        else                tag = "R2";
        npc_e = redir ? tg : (st ? m_pc : m_pc + STEP);
        chk({tag, " npc"}, npc_o, npc_e);
        chk({tag, " R5 kill_if"}, {31'd0, kill_if_o}, {31'd0, redir});
        chk({tag, " R5 kill_id"}, {31'd0, kill_id_o}, {31'd0, redir && m_v[0]});
        v_n[0] = redir ? 1'b0 : (st ? m_v[0] : 1'b1);
        v_n[1] = (redir || st) ? 1'b0 : m_v[0];
        for (int i = 2; i < NSTG; i++) v_n[i] = m_v[i-1];
        @(posedge clk);
        @(negedge clk);
        m_pc = npc_e;
        m_v  = v_n;
        chk({tag, " pc"}, pc_o, m_pc);
        chk({tag, " R8 R5 valid"}, {28'd0, vld_o}, {28'd0, m_v});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        stall_i = 1'b0; ex_resolve_i = 1'b1; ex_redirect_i = 1'b1; ex_target_i = 32'hdead_0000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R1 pc", pc_o, RV);
        chk("R1 valid", {28'd0, vld_o}, 32'd0);
        rst  = 1'b0;
        m_pc = RV;
        m_v  = '0;
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [3:0]  mem_seen;
        do_reset();

        // R2: plain sequential fetch
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, 32'h0);

        // R9: branch in execute redirects, memory stage sees 1,0,0,1
        step(1'b0, 1'b1, 1'b1, 32'h0000_2000);
        mem_seen[0] = vld_o[2];
        for (int k = 1; k < 4; k++) begin
            step(1'b0, 1'b0, 1'b0, 32'h0);
            mem_seen[k] = vld_o[2];
        end
        chk("R9 bubble pattern", {28'd0, mem_seen}, 32'h9);
        chk("R4 target fetched", pc_o, 32'h0000_2000 + 3 * STEP);

        // R6: redirect while stalled
        step(1'b1, 1'b1, 1'b1, 32'h0000_3000);
        chk("R6 pc after stalled redirect", pc_o, 32'h0000_3000);

        // R7: resolve on a bubble in execute (it was just squashed)
        step(1'b0, 1'b1, 1'b1, 32'h0000_4000);
        chk("R7 bubble resolve ignored", pc_o, 32'h0000_3000 + STEP);

        // Near-exhaustive sweep of input combinations from many states
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                step(c[2], c[1], c[0], 32'h0001_0000 + 32'(r * 256 + c * 16));
                step(1'b0, 1'b0, 1'b0, 32'h0);
            end
        end

        // Long pseudo-random run
        lfsr = 32'h1234_5679;
        for (int k = 0; k < 3000; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[1:0] == 2'b00, lfsr[4:2] == 3'b000 ? 1'b0 : lfsr[5],
                 lfsr[6] | lfsr[7], {lfsr[31:8], 8'h00});
        end

        // R1 again, after activity
        do_reset();
        step(1'b0, 1'b0, 1'b0, 32'h0);
        chk("R2 first step after reset", pc_o, RV + STEP);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule